// File: doc/BRIEF.md
# Memory Test Data Background Generator

This block produces the data word a memory tester writes to, and later expects back from, any cell address under a chosen background. A request carries a row address, a column address, a background code, a test round number, a seed and an invert flag. One clock later the block presents the word of configurable width. The same inputs always give the same word, so the read-back checker regenerates the written data exactly from the address and round. It needs no storage of what was written.

Four backgrounds are static: their data depends only on the address. They are solid, checkerboard, row stripe and column stripe. Two are dynamic and change from one round to the next: a walking one, and a pseudo-random word mixed from the seed, round and address. Solid is the default background for long repeated retention runs, and unused codes fall back to it. The invert flag complements any background, which gives true and complement passes.

Top module: `bg_pattern_gen`

## Requirements
- R1: While rstN is low, dataOut is all zeros and dataValid is low.
- R2: When reqValid is high at a rising clock edge, the word for that request appears on dataOut after that edge and dataValid is high for exactly that one cycle. In a cycle with reqValid low, dataValid goes low and dataOut keeps its previous value.
- R3: Code 0 (solid) gives an all-zero word.
- R4: Code 1 (checkerboard) gives a word whose bits all equal rowAddr[0] XOR colAddr[0].
- R5: Code 2 (row stripe) gives a word whose bits all equal rowAddr[0].
- R6: Code 3 (column stripe) gives a word whose bits all equal colAddr[0].
- R7: Code 4 (walking) gives a word with only bit (roundIdx + colAddr) mod DATA_W set.
- R8: Code 5 (random) gives the following word. Take a key K = {roundIdx, rowAddr, colAddr}, with colAddr in the low bits. XOR each bit K[i] into bit i mod DATA_W of the seed to form x. Then apply MIX_STEPS times: shift x left by one, XOR in POLY if the bit shifted out was 1, then set x = x XOR (x >> MIX_SHIFT). The defaults are DATA_W=32, POLY=0x04C11DB7, MIX_STEPS=4 and MIX_SHIFT=5.
- R9: invert high complements every bit of the word for any code.
- R10: For codes 0 to 3, roundIdx and seed have no effect on dataOut.
- R11: Codes 6 and 7 behave as solid.
- R12: A random request repeated with identical inputs gives an identical word. A change of roundIdx alone gives a different word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| patSel | input | 3 | Background code |
| invert | input | 1 | Complement the generated word |
| rowAddr | input | ROW_W | Row address |
| colAddr | input | COL_W | Column address |
| roundIdx | input | ROUND_W | Test round number |
| seed | input | DATA_W | Seed for the random background |
| dataOut | output | DATA_W | Generated data word |
| dataValid | output | 1 | dataOut holds the result of the previous request |

## Verification
Every word is due one clock after the edge that samples reqValid. The bench drives each request on a falling edge and holds it through one rising edge. It then compares dataOut and dataValid on the next falling edge, half a period after the output register has updated. One falling edge later it checks that dataValid has dropped and that the word has held. This confirms that each result lasts exactly one cycle and that requests do not interact.

// File: rtl/bg_pattern_pkg.sv
package bg_pattern_pkg;

  typedef enum logic [2:0] {
    BG_SOLID   = 3'd0,
    BG_CHECKER = 3'd1,
    BG_ROWSTR  = 3'd2,
    BG_COLSTR  = 3'd3,
    BG_WALK    = 3'd4,
    BG_RANDOM  = 3'd5
  } bgKind_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic    load;
    logic    inv;
    bgKind_e kind;
  } bgStrobe_t;

endpackage

// File: rtl/bg_pattern_ctrl.sv
module bg_pattern_ctrl
  import bg_pattern_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] patSel,
  input  logic       invert,
  output bgStrobe_t  strb
);

  // Codes beyond the defined set collapse onto the solid background (R11)
  always_comb begin
    strb.load = reqValid;
    strb.inv  = invert;
    case (patSel)
      3'd1:    strb.kind = BG_CHECKER;
      3'd2:    strb.kind = BG_ROWSTR;
      3'd3:    strb.kind = BG_COLSTR;
      3'd4:    strb.kind = BG_WALK;
      3'd5:    strb.kind = BG_RANDOM;
      default: strb.kind = BG_SOLID;
    endcase
  end

endmodule

// File: rtl/bg_pattern_dp.sv
module bg_pattern_dp
  import bg_pattern_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int ROUND_W   = 8,
  parameter int MIX_STEPS = 4,
  parameter int MIX_SHIFT = 5,
  parameter logic [DATA_W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic                clk,
  input  logic                rstN,
  input  bgStrobe_t           strb,
  input  logic [ROW_W-1:0]    rowAddr,
  input  logic [COL_W-1:0]    colAddr,
  input  logic [ROUND_W-1:0]  roundIdx,
  input  logic [DATA_W-1:0]   seed,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataValid
);

  localparam int KEY_W = ROUND_W + ROW_W + COL_W;
  localparam int SUM_W = ((ROUND_W > COL_W) ? ROUND_W : COL_W) + 1;
  localparam logic [DATA_W-1:0] ONE_HOT0 = DATA_W'(1);

  logic [DATA_W-1:0] checkWord, rowWord, colWord, walkWord, randWord;
  logic [DATA_W-1:0] baseWord, nextWord;
  logic [SUM_W-1:0]  walkSum, walkPos;
  logic [KEY_W-1:0]  key;
  logic [DATA_W-1:0] folded;
  logic [DATA_W-1:0] mixState [MIX_STEPS+1];

  // Address-derived static backgrounds
  assign checkWord = {DATA_W{rowAddr[0] ^ colAddr[0]}};
  assign rowWord   = {DATA_W{rowAddr[0]}};
  assign colWord   = {DATA_W{colAddr[0]}};

  // Walking one: position advances with the round and the column
  assign walkSum  = SUM_W'(roundIdx) + SUM_W'(colAddr);
  assign walkPos  = walkSum % SUM_W'(DATA_W);
  assign walkWord = ONE_HOT0 << walkPos;

  // Pseudo-random background: fold key into seed, then linear mixing
  assign key = {roundIdx, rowAddr, colAddr};

  always_comb begin
    folded = '0;
    for (int i = 0; i < KEY_W; i++) begin
      folded[i % DATA_W] = folded[i % DATA_W] ^ key[i];
    end
  end

  assign mixState[0] = seed ^ folded;

  generate
    for (genvar s = 0; s < MIX_STEPS; s++) begin : g_mix
      logic [DATA_W-1:0] stepped;
      assign stepped = {mixState[s][DATA_W-2:0], 1'b0}
                     ^ (mixState[s][DATA_W-1] ? POLY : '0);
      assign mixState[s+1] = stepped ^ (stepped >> MIX_SHIFT);
    end
  endgenerate

  assign randWord = mixState[MIX_STEPS];

  always_comb begin
    case (strb.kind)
      BG_CHECKER: baseWord = checkWord;
      BG_ROWSTR:  baseWord = rowWord;
      BG_COLSTR:  baseWord = colWord;
      BG_WALK:    baseWord = walkWord;
      BG_RANDOM:  baseWord = randWord;
      default:    baseWord = '0;
    endcase
    nextWord = strb.inv ? ~baseWord : baseWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strb.load;
      if (strb.load) dataOut <= nextWord;
    end
  end

  // One-cycle latency of the valid flag
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> dataValid);
  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !dataValid);
  // Output holds between requests
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(dataOut));
  // Solid follows only the invert flag
  assert_solid_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.kind == BG_SOLID) |=> (dataOut == {DATA_W{$past(strb.inv)}}));
  // Stripe and checker words are uniform
  assert_uniform_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && (strb.kind == BG_CHECKER || strb.kind == BG_ROWSTR ||
                   strb.kind == BG_COLSTR))
    |=> (dataOut == '0 || dataOut == '1));
  // Walking word carries exactly one set bit
  assert_walk_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.kind == BG_WALK && !strb.inv) |=> $onehot(dataOut));

endmodule

// File: rtl/bg_pattern_gen.sv
module bg_pattern_gen
  import bg_pattern_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int ROUND_W   = 8,
  parameter int MIX_STEPS = 4,
  parameter int MIX_SHIFT = 5,
  parameter logic [DATA_W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [2:0]          patSel,
  input  logic                invert,
  input  logic [ROW_W-1:0]    rowAddr,
  input  logic [COL_W-1:0]    colAddr,
  input  logic [ROUND_W-1:0]  roundIdx,
  input  logic [DATA_W-1:0]   seed,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataValid
);

  bgStrobe_t strb;

  bg_pattern_ctrl u_ctrl (
    .reqValid (reqValid),
    .patSel   (patSel),
    .invert   (invert),
    .strb     (strb)
  );

  bg_pattern_dp #(
    .DATA_W    (DATA_W),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .ROUND_W   (ROUND_W),
    .MIX_STEPS (MIX_STEPS),
    .MIX_SHIFT (MIX_SHIFT),
    .POLY      (POLY)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rowAddr   (rowAddr),
    .colAddr   (colAddr),
    .roundIdx  (roundIdx),
    .seed      (seed),
    .dataOut   (dataOut),
    .dataValid (dataValid)
  );

endmodule

// File: tb/tb_bg_pattern_gen.sv
module tb_bg_pattern_gen;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  patSel;
  logic        invert;
  logic [11:0] rowAddr;
  logic [9:0]  colAddr;
  logic [7:0]  roundIdx;
  logic [31:0] seed;
  logic [31:0] dataOut;
  logic        dataValid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bg_pattern_gen dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .patSel(patSel),
    .invert(invert), .rowAddr(rowAddr), .colAddr(colAddr),
    .roundIdx(roundIdx), .seed(seed), .dataOut(dataOut), .dataValid(dataValid)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic        inv;
    logic [11:0] row;
    logic [9:0]  col;
    logic [7:0]  rnd;
    logic [31:0] sd;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b0, 12'd5,    10'd3,    8'd9,   32'hDEADBEEF, 32'h00000000},
    '{3'd0, 1'b1, 12'd5,    10'd3,    8'd9,   32'hDEADBEEF, 32'hFFFFFFFF},
    '{3'd1, 1'b0, 12'd1,    10'd0,    8'd0,   32'h0,        32'hFFFFFFFF},
    '{3'd1, 1'b0, 12'd1,    10'd1,    8'd0,   32'h0,        32'h00000000},
    '{3'd1, 1'b1, 12'd2,    10'd5,    8'd0,   32'h0,        32'h00000000},
    '{3'd2, 1'b0, 12'd3,    10'd0,    8'd0,   32'h0,        32'hFFFFFFFF},
    '{3'd2, 1'b0, 12'd4,    10'd7,    8'd0,   32'h0,        32'h00000000},
    '{3'd3, 1'b0, 12'd4,    10'd7,    8'd0,   32'h0,        32'hFFFFFFFF},
    '{3'd3, 1'b1, 12'd7,    10'd2,    8'd0,   32'h0,        32'hFFFFFFFF},
    '{3'd4, 1'b0, 12'd0,    10'd0,    8'd0,   32'h0,        32'h00000001},
    '{3'd4, 1'b0, 12'd9,    10'd5,    8'd3,   32'h0,        32'h00000100},
    '{3'd4, 1'b0, 12'd9,    10'd5,    8'd30,  32'h0,        32'h00000008},
    '{3'd4, 1'b0, 12'hFFF,  10'd1023, 8'd255, 32'h0,        32'h40000000},
    '{3'd4, 1'b1, 12'd0,    10'd0,    8'd1,   32'h0,        32'hFFFFFFFD},
    '{3'd6, 1'b0, 12'd3,    10'd3,    8'd3,   32'h12345678, 32'h00000000},
    '{3'd7, 1'b1, 12'd3,    10'd3,    8'd3,   32'h12345678, 32'hFFFFFFFF},
    '{3'd1, 1'b0, 12'd1,    10'd0,    8'd77,  32'hCAFEF00D, 32'hFFFFFFFF}
  };

  function automatic string reqOf(input logic [2:0] s, input logic inv);
    if (inv && s != 3'd0) return "R9";
    case (s)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R11";
    endcase
  endfunction

  // Independent model of the random background, written from R8
  function automatic logic [31:0] randModel(input logic [31:0] sd, input logic [7:0] rnd,
                                            input logic [11:0] row, input logic [9:0] col);
    logic [29:0] k;
    logic [31:0] x;
    logic        top;
    k = {rnd, row, col};
    x = sd;
    for (int i = 0; i < 30; i++) x[i % 32] = x[i % 32] ^ k[i];
    for (int st = 0; st < 4; st++) begin
      top = x[31];
      x = x << 1;
      if (top) x = x ^ 32'h04C11DB7;
      x = x ^ {5'b0, x[31:5]};
    end
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drives one request and returns the word seen one cycle later
  task automatic request(input logic [2:0] s, input logic inv, input logic [11:0] r,
                         input logic [9:0] c, input logic [7:0] rn, input logic [31:0] sd,
                         output logic [31:0] word);
    @(negedge clk);
    reqValid = 1'b1; patSel = s; invert = inv;
    rowAddr = r; colAddr = c; roundIdx = rn; seed = sd;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 valid", {31'b0, dataValid}, 32'd1);
    word = dataOut;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] w, w2, held;
    rstN = 1'b0; reqValid = 1'b0; patSel = 3'd0; invert = 1'b0;
    rowAddr = '0; colAddr = '0; roundIdx = '0; seed = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 data", dataOut, 32'h0);
    check("R1 valid", {31'b0, dataValid}, 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      request(VECS[v].sel, VECS[v].inv, VECS[v].row, VECS[v].col,
              VECS[v].rnd, VECS[v].sd, w);
      check(reqOf(VECS[v].sel, VECS[v].inv), w, VECS[v].exp);
    end

    // R2: idle cycle drops valid and holds the word
    request(3'd1, 1'b0, 12'd1, 10'd0, 8'd0, 32'h0, held);
    inputsScramble: begin
      patSel = 3'd4; rowAddr = 12'd0; colAddr = 10'd7; roundIdx = 8'd2;
    end
    @(negedge clk);
    check("R2 drop", {31'b0, dataValid}, 32'd0);
    check("R2 hold", dataOut, held);

    // R10: static backgrounds ignore round and seed
    for (int s = 0; s < 4; s++) begin
      request(3'(s), 1'b0, 12'd6, 10'd3, 8'd0, 32'h0, w);
      request(3'(s), 1'b0, 12'd6, 10'd3, 8'd200, 32'hA5A5A5A5, w2);
      check("R10", w2, w);
    end

    // R8: random background against the model
    request(3'd5, 1'b0, 12'd0, 10'd0, 8'd0, 32'h0, w);
    check("R8", w, randModel(32'h0, 8'd0, 12'd0, 10'd0));
    request(3'd5, 1'b0, 12'hABC, 10'h155, 8'd17, 32'h13579BDF, w);
    check("R8", w, randModel(32'h13579BDF, 8'd17, 12'hABC, 10'h155));
    request(3'd5, 1'b0, 12'hFFF, 10'h3FF, 8'hFF, 32'hFFFFFFFF, w);
    check("R8", w, randModel(32'hFFFFFFFF, 8'hFF, 12'hFFF, 10'h3FF));
    // R9: inverted random
    request(3'd5, 1'b1, 12'h123, 10'h2A, 8'd4, 32'h0BADCAFE, w);
    check("R9", w, ~randModel(32'h0BADCAFE, 8'd4, 12'h123, 10'h2A));

    // R12: regeneration and round dependence
    request(3'd5, 1'b0, 12'h321, 10'h99, 8'd10, 32'h55AA33CC, w);
    request(3'd7, 1'b0, 12'h0, 10'h0, 8'd0, 32'h0, w2);
    request(3'd5, 1'b0, 12'h321, 10'h99, 8'd10, 32'h55AA33CC, w2);
    check("R12 repeat", w2, w);
    request(3'd5, 1'b0, 12'h321, 10'h99, 8'd11, 32'h55AA33CC, w2);
    check("R12 round", {31'b0, (w2 != w)}, 32'd1);

    // R1: reset clears a loaded word
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 data", dataOut, 32'h0);
    check("R1 valid", {31'b0, dataValid}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule